// File: doc/BRIEF.md
# Set-associative TLB pair with ordered protection checks

This block holds two translation buffers, one serving instruction fetches and one serving data reads and writes, each organised as 4 ways by 16 sets. A lookup takes a 32-bit virtual address, an access kind, a user-mode flag, the current 8-bit process ID and a check-enable configuration word. It answers in the same cycle with a hit flag, the physical address, read/write/execute permissions and an exception vector number. A tag match can still become a fault through an ordered series of protection checks, each with its own vector offset. Which buffer is searched follows from the access kind.

Entries are loaded through a write port addressed by buffer side, way and set. A flush command walks every entry of both buffers, one per cycle. It drops the valid bit of each entry that is valid, not global and owned by the given process ID.

Top module: `tlb_pair`

## Requirements
- R1: The virtual page is `lk_vaddr[31:13]`. The set index is `lk_vaddr[16:13]`. All 4 ways of the selected set compare their stored page (entry high word bits [31:13]) with the virtual page.
- R2: A way matches only when its page is equal and either its global flag (low word bit 4) is set or its stored process ID (high word bits [7:0]) equals `cur_pid`.
- R3: When several ways match, the lowest-numbered way supplies the result.
- R4: On a hit, `paddr` is the matched frame number (low word bits [31:13]) followed by `lk_vaddr[12:0]`.
- R5: `lk_kind` 2 (execute) searches the instruction side, whose vector base is 4. Kinds 0 (read), 1 (write) and 3 (treated as read) search the data side, whose vector base is 8. `wr_side` 0 loads the instruction side and 1 loads the data side.
- R6: The kernel check has first priority. It faults with vector base+2 when `chk_cfg[18]` is set, the entry's kernel flag (low bit 2) is set and `lk_user` is 1.
- R7: The write check comes next. It faults with base+3 for kind 1 when `chk_cfg[19]` is set and the entry's write flag (low bit 1) is clear.
- R8: The execute check comes next. It faults with base+3 for kind 2 when `chk_cfg[17]` is set and the entry's execute flag (low bit 0) is clear.
- R9: The valid check comes last. It faults with base+1 when `chk_cfg[16]` is set and the entry's valid flag (low bit 3) is clear. With `chk_cfg[16]` clear, an invalid entry still hits.
- R10: When no way matches, `hit` and all permissions are 0 and `vec` equals the side's base.
- R11: On a hit, `perm_r` is 1 and `perm_w` follows the entry's write flag. `perm_x` is 1 only on the instruction side, when `chk_cfg[17]` or the entry's execute flag is set.
- R12: A `flush_req` pulse while idle raises `flush_busy` from the next cycle for exactly 128 cycles. During that time the valid flag of every valid, non-global entry whose ID equals `flush_pid` is cleared in both sides, and no other field or entry changes. A `flush_req` while busy is ignored.
- R13: Reset clears every field of every entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_user | input | 1 | Access made in user mode |
| cur_pid | input | 8 | Current process ID |
| chk_cfg | input | 32 | Check enables: bit 16 valid, 17 execute, 18 kernel, 19 write |
| wr_en | input | 1 | Load one entry |
| wr_side | input | 1 | 0 instruction, 1 data |
| wr_way | input | 2 | Way to load |
| wr_idx | input | 4 | Set to load |
| wr_hi | input | 32 | Entry high word: page [31:13], ID [7:0] |
| wr_lo | input | 32 | Entry low word: frame [31:13], flags [4:0] |
| flush_req | input | 1 | Start a flush by process ID |
| flush_pid | input | 8 | Process ID to flush |
| flush_busy | output | 1 | Flush walk in progress |
| hit | output | 1 | Lookup translated without fault |
| paddr | output | 32 | Physical address |
| perm_r | output | 1 | Read permitted |
| perm_w | output | 1 | Write permitted |
| perm_x | output | 1 | Execute permitted |
| vec | output | 4 | Exception vector number |

## Verification
The assertions assume that no entry is loaded while a flush walk is running. Without that rule, the cleared result for an entry would depend on which of the two updates lands last. The bench issues all loads before it starts a flush and waits for `flush_busy` to drop before it loads again. The remaining properties relate the lookup inputs to the outputs in the same cycle, so the bench holds each lookup stable across a sampling point away from the clock edge.

// File: rtl/tlb_pair.sv
module tlb_pair #(
  parameter int WAYS     = 4,
  parameter int SET_BITS = 4,
  parameter int PID_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [31:0]             lk_vaddr,
  input  logic [1:0]              lk_kind,
  input  logic                    lk_user,
  input  logic [PID_W-1:0]        cur_pid,
  input  logic [31:0]             chk_cfg,
  input  logic                    wr_en,
  input  logic                    wr_side,
  input  logic [$clog2(WAYS)-1:0] wr_way,
  input  logic [SET_BITS-1:0]     wr_idx,
  input  logic [31:0]             wr_hi,
  input  logic [31:0]             wr_lo,
  input  logic                    flush_req,
  input  logic [PID_W-1:0]        flush_pid,
  output logic                    flush_busy,
  output logic                    hit,
  output logic [31:0]             paddr,
  output logic                    perm_r,
  output logic                    perm_w,
  output logic                    perm_x,
  output logic [3:0]              vec
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int WAY_W = $clog2(WAYS);
  localparam int PG    = 13;
  localparam int VPN_W = 32 - PG;
  localparam int PTR_W = 1 + WAY_W + SET_BITS;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(2 * WAYS * SETS - 1);
  localparam int C_V = 16, C_X = 17, C_K = 18, C_W = 19;
  localparam int F_X = 0, F_W = 1, F_K = 2, F_V = 3, F_G = 4;

  logic [VPN_W-1:0] e_vpn [2][WAYS][SETS];
  logic [PID_W-1:0] e_pid [2][WAYS][SETS];
  logic [VPN_W-1:0] e_pfn [2][WAYS][SETS];
  logic [4:0]       e_fl  [2][WAYS][SETS];

  logic [PTR_W-1:0] ptr;
  logic [PID_W-1:0] fpid;
  wire              fs = ptr[PTR_W-1];
  wire [WAY_W-1:0]  fw = ptr[SET_BITS +: WAY_W];
  wire [SET_BITS-1:0] fi = ptr[SET_BITS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_busy <= 1'b0;
      ptr        <= '0;
      fpid       <= '0;
    end else if (!flush_busy) begin
      if (flush_req) begin
        flush_busy <= 1'b1;
        ptr        <= '0;
        fpid       <= flush_pid;
      end
    end else if (ptr == LAST) begin
      flush_busy <= 1'b0;
    end else begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < WAYS; w++)
          for (int i = 0; i < SETS; i++) begin
            e_vpn[s][w][i] <= '0;
            e_pid[s][w][i] <= '0;
            e_pfn[s][w][i] <= '0;
            e_fl[s][w][i]  <= '0;
          end
    end else begin
      if (flush_busy && e_fl[fs][fw][fi][F_V] && !e_fl[fs][fw][fi][F_G]
          && e_pid[fs][fw][fi] == fpid)
        e_fl[fs][fw][fi][F_V] <= 1'b0;
      if (wr_en) begin
        e_vpn[wr_side][wr_way][wr_idx] <= wr_hi[31:PG];
        e_pid[wr_side][wr_way][wr_idx] <= wr_hi[PID_W-1:0];
        e_pfn[wr_side][wr_way][wr_idx] <= wr_lo[31:PG];
        e_fl[wr_side][wr_way][wr_idx]  <= wr_lo[4:0];
      end
    end
  end

  wire                side = (lk_kind != 2'd2);
  wire [SET_BITS-1:0] idx  = lk_vaddr[PG +: SET_BITS];
  wire [VPN_W-1:0]    vpn  = lk_vaddr[31:PG];
  wire [3:0]          base = side ? 4'd8 : 4'd4;

  logic [WAYS-1:0]  way_match;
  logic [WAY_W-1:0] sel_way;
  logic             tag_hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_match[w] = (e_vpn[side][w][idx] == vpn)
                       && (e_fl[side][w][idx][F_G] || e_pid[side][w][idx] == cur_pid);
  end

  always_comb begin
    sel_way = '0;
    tag_hit = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (way_match[w]) begin
        sel_way = WAY_W'(w);
        tag_hit = 1'b1;
      end
  end

  wire [4:0]       fl  = e_fl[side][sel_way][idx];
  wire [VPN_W-1:0] pfn = e_pfn[side][sel_way][idx];

  wire f_k = chk_cfg[C_K] & fl[F_K] & lk_user;
  wire f_w = (lk_kind == 2'd1) & chk_cfg[C_W] & ~fl[F_W];
  wire f_x = (lk_kind == 2'd2) & chk_cfg[C_X] & ~fl[F_X];
  wire f_v = chk_cfg[C_V] & ~fl[F_V];

  always_comb begin
    if (!tag_hit)        vec = base;
    else if (f_k)        vec = base + 4'd2;
    else if (f_w || f_x) vec = base + 4'd3;
    else if (f_v)        vec = base + 4'd1;
    else                 vec = base;
  end

  assign hit    = tag_hit & ~(f_k | f_w | f_x | f_v);
  assign paddr  = tag_hit ? {pfn, lk_vaddr[PG-1:0]} : '0;
  assign perm_r = hit;
  assign perm_w = hit & fl[F_W];
  assign perm_x = hit & ~side & (chk_cfg[C_X] | fl[F_X]);

  assert_xperm_instr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    perm_x |-> (lk_kind == 2'd2));
  assert_miss_noperm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (!perm_r && !perm_w && !perm_x));
  assert_fault_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_hit && !hit) |-> (vec[1:0] != 2'b00));
  assert_flush_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_busy) |-> $past(flush_req));
  assert_no_load_in_flush_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && flush_busy));
endmodule

// File: tb/tlb_pair_tb_top.sv
module tlb_pair_tb_top;
  localparam int PER = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] lk_vaddr = '0, chk_cfg = '0, wr_hi = '0, wr_lo = '0, paddr;
  logic [1:0]  lk_kind = '0, wr_way = '0;
  logic        lk_user = 1'b0, wr_en = 1'b0, wr_side = 1'b0, flush_req = 1'b0;
  logic [7:0]  cur_pid = '0, flush_pid = '0;
  logic [3:0]  wr_idx = '0, vec;
  logic        flush_busy, hit, perm_r, perm_w, perm_x;
  int          n_run = 0, n_fail = 0;

  always #(PER/2) clk = ~clk;

  tlb_pair dut_i (.clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .lk_user(lk_user), .cur_pid(cur_pid), .chk_cfg(chk_cfg), .wr_en(wr_en),
    .wr_side(wr_side), .wr_way(wr_way), .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .flush_req(flush_req), .flush_pid(flush_pid), .flush_busy(flush_busy), .hit(hit),
    .paddr(paddr), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x), .vec(vec));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfgv(bit w, bit k, bit x, bit v);
    return {12'b0, w, k, x, v, 16'b0};
  endfunction

  // flags order {global, valid, kernel, write, execute}
  task automatic load(bit side, int way, logic [18:0] vp, logic [7:0] pid,
                      logic [18:0] pf, logic [4:0] fl);
    @(negedge clk);
    wr_en = 1'b1; wr_side = side; wr_way = 2'(way); wr_idx = vp[3:0];
    wr_hi = {vp, 5'b0, pid}; wr_lo = {pf, 8'b0, fl};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(logic [1:0] kind, bit user, logic [7:0] pid, logic [18:0] vp,
                      logic [31:0] cfg);
    @(negedge clk);
    lk_kind = kind; lk_user = user; cur_pid = pid; chk_cfg = cfg;
    lk_vaddr = {vp, 13'h0A5};
    #1;
  endtask

  task automatic t_reset;
    chk("R13 busy after reset", flush_busy, 0);
    look(0, 0, 8'd1, 19'h00000, 0);
    chk("R13 empty read miss", hit, 0);
    chk("R10 miss data base", vec, 8);
    chk("R10 miss no perm", {perm_r, perm_w, perm_x}, 0);
    look(2, 0, 8'd1, 19'h00000, 0);
    chk("R5 empty exec base", vec, 4);
  endtask

  task automatic t_basic;
    load(1, 0, 19'h12345, 8'd3, 19'h0ABCD, 5'b01010);
    look(0, 0, 8'd3, 19'h12345, cfgv(1, 1, 1, 1));
    chk("R1 tag hit", hit, 1);
    chk("R4 paddr", paddr, {19'h0ABCD, 13'h0A5});
    chk("R11 data perms", {perm_r, perm_w, perm_x}, 3'b110);
    look(0, 0, 8'd4, 19'h12345, 0);
    chk("R2 pid mismatch miss", hit, 0);
    look(0, 0, 8'd3, 19'h22345, 0);
    chk("R1 same set other page miss", hit, 0);
    chk("R10 miss vec", vec, 8);
    look(2, 0, 8'd3, 19'h12345, 0);
    chk("R5 exec ignores data side", {hit, vec}, {1'b0, 4'd4});
  endtask

  task automatic t_global;
    load(1, 1, 19'h00036, 8'd9, 19'h00777, 5'b11000);
    look(0, 0, 8'd2, 19'h00036, 0);
    chk("R2 global hits other pid", hit, 1);
    chk("R11 no write perm", perm_w, 0);
  endtask

  task automatic t_way;
    load(1, 3, 19'h00707, 8'd1, 19'h03333, 5'b01010);
    load(1, 1, 19'h00707, 8'd0, 19'h01111, 5'b11010);
    look(1, 0, 8'd1, 19'h00707, 0);
    chk("R3 lowest way wins", paddr, {19'h01111, 13'h0A5});
  endtask

  task automatic t_exec;
    load(0, 2, 19'h50003, 8'd7, 19'h11111, 5'b01000);
    look(2, 0, 8'd7, 19'h50003, 0);
    chk("R11 exec hit no xperm", {hit, perm_x}, 2'b10);
    look(2, 0, 8'd7, 19'h50003, cfgv(0, 0, 1, 0));
    chk("R8 exec fault vec", {hit, vec}, {1'b0, 4'd7});
    load(0, 2, 19'h50003, 8'd7, 19'h11111, 5'b01001);
    look(2, 0, 8'd7, 19'h50003, cfgv(0, 0, 1, 0));
    chk("R11 exec perm", {hit, perm_x, perm_w}, 3'b110);
    look(0, 0, 8'd7, 19'h50003, 0);
    chk("R5 read ignores instr side", {hit, vec}, {1'b0, 4'd8});
  endtask

  task automatic t_prot;
    load(1, 0, 19'h40009, 8'd2, 19'h0BEEF, 5'b00100);
    look(1, 1, 8'd2, 19'h40009, cfgv(1, 1, 1, 1));
    chk("R6 kernel first", {hit, vec}, {1'b0, 4'd10});
    look(0, 1, 8'd2, 19'h40009, cfgv(1, 1, 1, 1));
    chk("R6 user read kernel page", vec, 10);
    look(1, 0, 8'd2, 19'h40009, cfgv(1, 1, 1, 1));
    chk("R7 write fault", {hit, vec}, {1'b0, 4'd11});
    look(0, 0, 8'd2, 19'h40009, cfgv(1, 1, 1, 1));
    chk("R9 invalid fault", {hit, vec}, {1'b0, 4'd9});
    chk("R4 paddr on fault", paddr, {19'h0BEEF, 13'h0A5});
    look(0, 0, 8'd2, 19'h40009, cfgv(1, 1, 1, 0));
    chk("R9 invalid hits when unchecked", {hit, perm_w, perm_x}, 3'b100);
  endtask

  task automatic t_flush;
    int cnt;
    load(1, 0, 19'h00012, 8'd5, 19'h0000A, 5'b01000);
    load(1, 1, 19'h00022, 8'd5, 19'h0000B, 5'b11000);
    load(1, 2, 19'h00032, 8'd6, 19'h0000C, 5'b01000);
    load(0, 0, 19'h00012, 8'd5, 19'h0000D, 5'b01001);
    @(negedge clk);
    flush_req = 1'b1; flush_pid = 8'd5;
    @(negedge clk);
    flush_req = 1'b0;
    chk("R12 busy next cycle", flush_busy, 1);
    cnt = 1;
    while (flush_busy) begin
      @(negedge clk);
      if (flush_busy) cnt++;
      flush_req = (cnt == 10);
    end
    flush_req = 1'b0;
    chk("R12 busy length", cnt, 128);
    look(0, 0, 8'd5, 19'h00012, cfgv(0, 0, 0, 1));
    chk("R12 owned entry cleared", {hit, vec}, {1'b0, 4'd9});
    look(0, 0, 8'd5, 19'h00012, 0);
    chk("R12 other fields kept", {hit, paddr}, {1'b1, 19'h0000A, 13'h0A5});
    look(0, 0, 8'd0, 19'h00022, cfgv(0, 0, 0, 1));
    chk("R12 global kept", hit, 1);
    look(0, 0, 8'd6, 19'h00032, cfgv(0, 0, 0, 1));
    chk("R12 other pid kept", hit, 1);
    look(2, 0, 8'd5, 19'h00012, cfgv(0, 0, 0, 1));
    chk("R12 instr side cleared", {hit, vec}, {1'b0, 4'd5});
  endtask

  initial begin
    #(PER * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_global();
    t_way();
    t_exec();
    t_prot();
    t_flush();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule